// File: doc/BRIEF.md
# Coprocessor Bus Control Registers

This block is the small control register set through which a main processor governs a secondary 8-bit processor. Three one-bit controls are written, each through its own strobe and data bit. The first requests the secondary processor's bus. The second holds the secondary processor in reset. The third shifts one bit into a bank register. The bank register selects which 32 KB window of the main 24-bit address space the secondary processor sees.

The block drives several outputs: a bus-acknowledge status, the active-low reset of the secondary processor, and a one-cycle reset pulse for a companion sound device. It also drives the window base address and an 8-bit readback word that carries the acknowledge status. A pending-interrupt flag for the secondary processor is set by an outside source and cleared by that processor's interrupt acknowledge. The acknowledge cycle presents an all-ones vector byte.

All state changes on the rising clock edge. Outputs follow from registered state, so a write becomes visible in the cycle after the edge that captures it. The exception is the vector byte, which follows the acknowledge input directly.

Top module: `cbc_bus_ctrl`

## Requirements
- R1: After reset, sub_rst_n is 0, bus_ack_n is 1, bank_base is 0, irq_pend is 0 and snd_rst_pulse is 0.
- R2: bus_ack_n equals NOT(request bit AND sub_rst_n). It is 0 (granted) only while the bus is requested and the secondary processor is released from reset.
- R3: A reset-control write with data 0 drives sub_rst_n to 0 (held). A write with data 1 drives it to 1 (released). The value shows from the cycle after the write edge.
- R4: Each reset-control write with data 0 makes snd_rst_pulse high for exactly one cycle after the write edge, even if reset was already held. A write with data 1 makes no pulse.
- R5: A bank write sets bank_base to the old value shifted right by one bit, with the written data bit placed in address bit 23.
- R6: bank_base bits 14 to 0 are always 0, so the window base is aligned to 32 KB.
- R7: Nine bank writes that carry a target address's bits in order from bit 15 up to bit 23 leave bank_base equal to that target.
- R8: irq_raise sets irq_pend from the next cycle. irq_ack without irq_raise clears it from the next cycle; if both are high in the same cycle, irq_raise wins. vec_data reads 0xFF while irq_ack is high and 0x00 otherwise.
- R9: rd_data bit 0 carries bus_ack_n and bits 7 to 1 are 0.
- R10: A data input has no effect unless its own strobe is high. A strobe changes only its own control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_we | input | 1 | Bus-request write strobe |
| req_d | input | 1 | Bus-request data bit, 1 = request |
| hold_we | input | 1 | Reset-control write strobe |
| hold_d | input | 1 | Reset-control data bit, 0 = hold, 1 = release |
| bank_we | input | 1 | Bank shift write strobe |
| bank_d | input | 1 | Bit shifted into the top of the bank register |
| irq_raise | input | 1 | Sets the pending interrupt |
| irq_ack | input | 1 | Interrupt acknowledge from the secondary processor |
| bus_ack_n | output | 1 | Bus acknowledge status, 0 = granted |
| sub_rst_n | output | 1 | Active-low reset to the secondary processor |
| snd_rst_pulse | output | 1 | One-cycle reset pulse to the sound device |
| bank_base | output | 24 | Base address of the secondary processor's window |
| irq_pend | output | 1 | Pending interrupt to the secondary processor |
| vec_data | output | 8 | Vector byte during an acknowledge |
| rd_data | output | 8 | Readback word, bit 0 = bus_ack_n |

## Verification
The properties assume that every input is driven to a known 0 or 1 at each rising edge. They also assume that the inputs hold 0 while rst_n is low, since the one-cycle-later checks look at the input values of the reset cycle. The stimulus meets both conditions: it changes inputs only on falling edges and keeps every strobe low through reset. It also sets data bits while their strobes are low, which exercises the ignored-data cases without breaking these assumptions.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   localparam int unsigned CBC_ADDR_W  = 24;
   localparam int unsigned CBC_WIN_LSB = 15;
   localparam int unsigned CBC_BYTE_W  = 8;

   function automatic logic [63:0] cbc_low_mask(input int unsigned lsb);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < lsb; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic req_we,
   input  logic req_d,
   input  logic hold_we,
   input  logic hold_d,
   output logic sub_rst_n,
   output logic bus_ack_n,
   output logic snd_rst_pulse
);
   logic req_q;
   logic rel_q;
   logic snd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         rel_q <= 1'b0;
         snd_q <= 1'b0;
      end else begin
         if (req_we)  req_q <= req_d;
         if (hold_we) rel_q <= hold_d;
         snd_q <= hold_we & ~hold_d;
      end
   end

   assign sub_rst_n     = rel_q;
   assign bus_ack_n     = ~(req_q & rel_q);
   assign snd_rst_pulse = snd_q;
endmodule

// File: rtl/cbc_bank_shift.sv
module cbc_bank_shift #(
   parameter int unsigned ADDR_W  = cbc_pkg::CBC_ADDR_W,
   parameter int unsigned WIN_LSB = cbc_pkg::CBC_WIN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic              bank_d,
   output logic [ADDR_W-1:0] bank_base
);
   localparam int unsigned TOP = ADDR_W - 1;

   logic [ADDR_W-1:0] base_q;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < WIN_LSB) begin : g_zero
         assign base_q[i] = 1'b0;
      end else begin : g_flop
         logic bit_q;
         logic bit_next;
         if (i == TOP) begin : g_top
            assign bit_next = bank_d;
         end else begin : g_mid
            assign bit_next = base_q[i+1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       bit_q <= 1'b0;
            else if (bank_we) bit_q <= bit_next;
         end
         assign base_q[i] = bit_q;
      end
   end

   assign bank_base = base_q;
endmodule

// File: rtl/cbc_irq_line.sv
module cbc_irq_line #(
   parameter int unsigned VEC_W   = cbc_pkg::CBC_BYTE_W,
   parameter logic [VEC_W-1:0] VEC_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_raise,
   input  logic             irq_ack,
   output logic             irq_pend,
   output logic [VEC_W-1:0] vec_data
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (irq_raise) pend_q <= 1'b1;
      else if (irq_ack)   pend_q <= 1'b0;
   end

   assign irq_pend = pend_q;
   assign vec_data = irq_ack ? VEC_VAL : '0;
endmodule

// File: rtl/cbc_bus_ctrl.sv
module cbc_bus_ctrl #(
   parameter int unsigned ADDR_W  = cbc_pkg::CBC_ADDR_W,
   parameter int unsigned WIN_LSB = cbc_pkg::CBC_WIN_LSB,
   parameter int unsigned RD_W    = cbc_pkg::CBC_BYTE_W,
   parameter int unsigned VEC_W   = cbc_pkg::CBC_BYTE_W,
   parameter logic [VEC_W-1:0] VEC_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_we,
   input  logic              req_d,
   input  logic              hold_we,
   input  logic              hold_d,
   input  logic              bank_we,
   input  logic              bank_d,
   input  logic              irq_raise,
   input  logic              irq_ack,
   output logic              bus_ack_n,
   output logic              sub_rst_n,
   output logic              snd_rst_pulse,
   output logic [ADDR_W-1:0] bank_base,
   output logic              irq_pend,
   output logic [VEC_W-1:0]  vec_data,
   output logic [RD_W-1:0]   rd_data
);
   localparam int unsigned WIN_BITS = ADDR_W - WIN_LSB;

   if (WIN_LSB >= ADDR_W || WIN_BITS < 1) begin : g_bad_window
      $error("cbc_bus_ctrl: window LSB must lie below the address width");
   end
   if (RD_W < 1) begin : g_bad_rd
      $error("cbc_bus_ctrl: readback width must be at least one bit");
   end

   cbc_ctrl_regs u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_we        (req_we),
      .req_d         (req_d),
      .hold_we       (hold_we),
      .hold_d        (hold_d),
      .sub_rst_n     (sub_rst_n),
      .bus_ack_n     (bus_ack_n),
      .snd_rst_pulse (snd_rst_pulse)
   );

   cbc_bank_shift #(
      .ADDR_W  (ADDR_W),
      .WIN_LSB (WIN_LSB)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_we   (bank_we),
      .bank_d    (bank_d),
      .bank_base (bank_base)
   );

   cbc_irq_line #(
      .VEC_W   (VEC_W),
      .VEC_VAL (VEC_VAL)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_raise (irq_raise),
      .irq_ack   (irq_ack),
      .irq_pend  (irq_pend),
      .vec_data  (vec_data)
   );

   if (RD_W > 1) begin : g_rd_wide
      assign rd_data = {{(RD_W-1){1'b0}}, bus_ack_n};
   end else begin : g_rd_bit
      assign rd_data = bus_ack_n;
   end
endmodule

// File: rtl/cbc_bus_ctrl_chk.sv
module cbc_bus_ctrl_chk #(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned WIN_LSB = 15,
   parameter int unsigned RD_W    = 8,
   parameter int unsigned VEC_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_we,
   input logic              req_d,
   input logic              hold_we,
   input logic              hold_d,
   input logic              bank_we,
   input logic              bank_d,
   input logic              irq_raise,
   input logic              irq_ack,
   input logic              bus_ack_n,
   input logic              sub_rst_n,
   input logic              snd_rst_pulse,
   input logic [ADDR_W-1:0] bank_base,
   input logic              irq_pend,
   input logic [VEC_W-1:0]  vec_data,
   input logic [RD_W-1:0]   rd_data
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(cbc_pkg::cbc_low_mask(WIN_LSB));

   AST_GRANT_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ack_n |-> sub_rst_n); // R2
   AST_REQ_DROP_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_we && !req_d) |=> bus_ack_n); // R2
   AST_HOLD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_we && !hold_d) |=> (!sub_rst_n && bus_ack_n)); // R3
   AST_SND_PULSE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_we && !hold_d) |=> snd_rst_pulse); // R4
   AST_SND_QUIET_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_we && !hold_d) |=> !snd_rst_pulse); // R4
   AST_BANK_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> (bank_base[ADDR_W-1] == $past(bank_d))); // R5
   AST_BANK_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> (bank_base[ADDR_W-2:WIN_LSB] == $past(bank_base[ADDR_W-1:WIN_LSB+1]))); // R5
   AST_BANK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_base & LOW_MASK) == '0); // R6
   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_we |=> $stable(bank_base)); // R10
   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_raise) |=> !irq_pend); // R8
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_raise |=> irq_pend); // R8
   AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_ack |-> (vec_data == '0)); // R8
   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data >> 1) == '0); // R9
   AST_RD_ACK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] == bus_ack_n); // R9
endmodule

bind cbc_bus_ctrl cbc_bus_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .WIN_LSB (WIN_LSB),
   .RD_W    (RD_W),
   .VEC_W   (VEC_W)
) u_chk (.*);

// File: tb/cbc_bus_ctrl_bench.sv
`timescale 1ns/1ps
module cbc_bus_ctrl_bench;
   localparam int AW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_we = 0, req_d = 0, hold_we = 0, hold_d = 0;
   logic bank_we = 0, bank_d = 0, irq_raise = 0, irq_ack = 0;
   logic          bus_ack_n, sub_rst_n, snd_rst_pulse, irq_pend;
   logic [AW-1:0] bank_base;
   logic [7:0]    vec_data, rd_data;

   always #4 clk = ~clk;

   cbc_bus_ctrl u_cbc_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_d(req_d),
      .hold_we(hold_we), .hold_d(hold_d), .bank_we(bank_we), .bank_d(bank_d),
      .irq_raise(irq_raise), .irq_ack(irq_ack), .bus_ack_n(bus_ack_n),
      .sub_rst_n(sub_rst_n), .snd_rst_pulse(snd_rst_pulse), .bank_base(bank_base),
      .irq_pend(irq_pend), .vec_data(vec_data), .rd_data(rd_data));

   typedef struct {
      logic          ack_n;
      logic          rstn;
      logic          snd;
      logic [AW-1:0] bank;
      logic          irq;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   popped = 0;
   int   pushed = 0;

   logic          m_req = 0, m_rstn = 0, m_irq = 0;
   logic [AW-1:0] m_bank = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic snd, input string tag);
      exp_t e;
      e.ack_n = ~(m_req & m_rstn);
      e.rstn  = m_rstn;
      e.snd   = snd;
      e.bank  = m_bank;
      e.irq   = m_irq;
      e.tag   = tag;
      q.push_back(e);
      pushed++;
   endtask

   // one cycle of stimulus: strobes set on a falling edge, captured on the
   // next rising edge, results compared on the following falling edge
   task automatic op(input int kind, input logic d, input string tag);
      logic snd;
      @(negedge clk);
      snd = 1'b0;
      case (kind)
         0: begin req_we = 1; req_d = d; m_req = d; end
         1: begin hold_we = 1; hold_d = d; m_rstn = d; snd = ~d; end
         2: begin bank_we = 1; bank_d = d; m_bank = {d, m_bank[AW-1:1]} & 24'hFF8000; end
         3: begin req_d = d; hold_d = ~d; bank_d = d; end
         default: ;
      endcase
      @(negedge clk);
      req_we = 0; hold_we = 0; bank_we = 0;
      push(snd, tag);
   endtask

   // monitor: pops expected items and compares as results appear
   initial begin
      forever begin
         wait (q.size() > 0);
         begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " bus_ack_n"}, 32'(bus_ack_n), 32'(e.ack_n));
            chk({e.tag, " sub_rst_n"}, 32'(sub_rst_n), 32'(e.rstn));
            chk({e.tag, " snd_rst_pulse"}, 32'(snd_rst_pulse), 32'(e.snd));
            chk({e.tag, " bank_base"}, 32'(bank_base), 32'(e.bank));
            chk({e.tag, " irq_pend"}, 32'(irq_pend), 32'(e.irq));
            chk({e.tag, " rd_data (R9)"}, 32'(rd_data), 32'({7'b0, e.ack_n}));
            popped++;
         end
      end
   end

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while held and right after release
      chk("R1 sub_rst_n in reset", 32'(sub_rst_n), 0);
      chk("R1 bus_ack_n in reset", 32'(bus_ack_n), 1);
      rst_n = 1'b1;
      op(-1, 0, "R1 idle after reset");

      // R2: request while held in reset is not granted
      op(0, 1, "R2 request while held");
      op(1, 1, "R3 release -> R2 granted");
      op(0, 0, "R2 request dropped");
      op(0, 1, "R2 request again");
      op(1, 0, "R3 hold, R4 pulse, R2 denied");
      op(-1, 0, "R4 pulse gone");
      op(1, 0, "R4 second hold write still pulses");
      op(1, 1, "R4 release gives no pulse");

      // R10: data moving with strobes low changes nothing
      op(3, 1, "R10 data without strobe");
      op(3, 0, "R10 data without strobe low");

      // R5 R6: single shifts
      op(2, 1, "R5 shift in one");
      op(2, 0, "R5 shift in zero");
      op(2, 1, "R6 alignment kept");

      // R7: nine writes, bit 15 first, for two targets
      begin
         logic [AW-1:0] tgt [2];
         tgt[0] = 24'hA58000;
         tgt[1] = 24'h7F8000;
         for (int t = 0; t < 2; t++) begin
            for (int b = 15; b < 24; b++) op(2, tgt[t][b], "R7 load bit");
            @(negedge clk);
            chk("R7 nine writes form target", 32'(bank_base), 32'(tgt[t]));
         end
      end
      op(2, 0, "R5 tenth write shifts out");

      // R8: interrupt set, ack with vector, simultaneous
      @(negedge clk); irq_raise = 1; m_irq = 1;
      @(negedge clk); irq_raise = 0; push(0, "R8 raise");
      @(negedge clk); irq_ack = 1;
      #1 chk("R8 vector during ack", 32'(vec_data), 32'hFF);
      m_irq = 0;
      @(negedge clk); irq_ack = 0; push(0, "R8 ack clears");
      #1 chk("R8 vector idle", 32'(vec_data), 0);
      @(negedge clk); irq_raise = 1; irq_ack = 1; m_irq = 1;
      @(negedge clk); irq_raise = 0; irq_ack = 0; push(0, "R8 raise wins");

      // R1: reset again mid-run
      @(negedge clk); rst_n = 0;
      m_req = 0; m_rstn = 0; m_bank = '0; m_irq = 0;
      @(negedge clk); rst_n = 1; push(0, "R1 re-reset");

      wait (popped == pushed);
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule